// File: doc/BRIEF.md
# Adder-Subtractor with Condition Flags

A combinational two's-complement adder/subtractor of parameter width `W` (32 bits by default). One mode input chooses between sum and difference. For a difference the B operand is bit-inverted and the carry into bit 0 is forced high, so one carry network serves both operations. A parallel-prefix carry tree produces every column carry. The carry out of the top column and the carry into the top column feed the flag logic.

Four condition flags come out with the result: negative, zero, carry and signed overflow. A small decode stage turns those flags into three magnitude indications: equal, unsigned greater-than and signed greater-than. These indications are meaningful when the block is subtracting. A surrounding datapath runs one subtraction and reads signed and unsigned comparisons from the same flag set.

Top module: `addsub_cc`

## Requirements
- R1: With `sub_i`=0, `res_o` equals (A+B) mod 2^W and `carry_o` is 1 exactly when the unsigned sum does not fit in W bits.
- R2: With `sub_i`=1, `res_o` equals (A-B) mod 2^W and `carry_o` is 1 when A >= B as unsigned numbers; `carry_o`=0 marks a borrow.
- R3: `ovf_o` is 1 exactly when the two's-complement result of the selected operation lies outside [-2^(W-1), 2^(W-1)-1]. Signed overflow is the XOR of the carry out of bit W-1 and the carry into bit W-1.
- R4: `neg_o` equals bit W-1 of `res_o`.
- R5: `zero_o` is 1 exactly when every bit of `res_o` is 0.
- R6: With `sub_i`=1, `eq_o` is 1 exactly when A equals B.
- R7: With `sub_i`=1, `ugt_o` is 1 exactly when A > B as unsigned numbers (carry set and zero clear).
- R8: With `sub_i`=1, `sgt_o` is 1 exactly when A > B as two's-complement numbers (negative equals overflow and zero clear). This holds for the most negative value and for equal operands.
- R9: The block holds no state. Every output depends only on the present inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | W | First operand (minuend when subtracting) |
| b_i | input | W | Second operand (subtrahend when subtracting) |
| sub_i | input | 1 | 0 selects A+B, 1 selects A-B |
| res_o | output | W | Result, modulo 2^W |
| neg_o | output | 1 | Negative flag |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry out of the top column |
| ovf_o | output | 1 | Signed overflow flag |
| eq_o | output | 1 | A equals B (subtract mode) |
| ugt_o | output | 1 | A greater than B, unsigned (subtract mode) |
| sgt_o | output | 1 | A greater than B, signed (subtract mode) |

## Verification
The bench builds two copies of the block. The first uses the default W=32 and is driven with directed corner operands (all-ones, the most negative and most positive values, equal pairs) and with several thousand random pairs. The second uses W=4, which keeps the operand space small enough to apply all 512 combinations of A, B and mode. At that width every carry-into-sign case, every signed and unsigned ordering and every overflow boundary is reached exhaustively, and each prefix level is still present.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef struct packed {
    logic neg;
    logic zero;
    logic carry;
    logic ovf;
  } cc_flags_t;

  typedef struct packed {
    logic eq;
    logic ugt;
    logic sgt;
  } cmp_t;
endpackage

// File: rtl/addsub_operand.sv
module addsub_operand #(
  parameter int W = 32
) (
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] b_eff_o,
  output logic         cin_o
);
  // subtract: A + ~B + 1
  assign b_eff_o = b_i ^ {W{sub_i}};
  assign cin_o   = sub_i;

  always_comb begin
    if (!$isunknown({b_i, sub_i})) begin
      p_inv_r2: assert ((b_eff_o + b_i == '1) || !sub_i);
    end
  end
endmodule

// File: rtl/addsub_prefix.sv
module addsub_prefix #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         cmsb_o
);
  localparam int LVL = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0] g [0:LVL];
  logic [W-1:0] p [0:LVL];
  logic [W:0]   c;

  assign g[0] = a_i & b_i;
  assign p[0] = a_i ^ b_i;

  // log-depth group generate/propagate
  for (genvar k = 0; k < LVL; k++) begin : g_lvl
    for (genvar i = 0; i < W; i++) begin : g_col
      if (i >= (1 << k)) begin : g_merge
        assign g[k+1][i] = g[k][i] | (p[k][i] & g[k][i-(1<<k)]);
        assign p[k+1][i] = p[k][i] & p[k][i-(1<<k)];
      end else begin : g_pass
        assign g[k+1][i] = g[k][i];
        assign p[k+1][i] = p[k][i];
      end
    end
  end

  assign c[0] = cin_i;
  for (genvar i = 0; i < W; i++) begin : g_carry
    assign c[i+1] = g[LVL][i] | (p[LVL][i] & cin_i);
  end

  assign sum_o  = p[0] ^ c[W-1:0];
  assign cout_o = c[W];
  assign cmsb_o = c[W-1];

  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i})) begin
      p_sum_r1: assert ({cout_o, sum_o} ==
                        ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}));
    end
  end
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
  import addsub_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] sum_i,
  input  logic         cout_i,
  input  logic         cmsb_i,
  input  logic         a_msb_i,
  input  logic         b_msb_i,
  output cc_flags_t    flags_o
);
  assign flags_o.neg   = sum_i[W-1];
  assign flags_o.zero  = ~|sum_i;
  assign flags_o.carry = cout_i;
  assign flags_o.ovf   = cout_i ^ cmsb_i;

  // carry-based overflow must agree with the sign-based rule
  always_comb begin
    if (!$isunknown({sum_i, cout_i, cmsb_i, a_msb_i, b_msb_i})) begin
      p_ovf_sign_r3: assert (flags_o.ovf ==
                             ((a_msb_i == b_msb_i) && (sum_i[W-1] != a_msb_i)));
    end
  end
endmodule

// File: rtl/addsub_cmp.sv
module addsub_cmp
  import addsub_pkg::*;
(
  input  cc_flags_t flags_i,
  output cmp_t      cmp_o
);
  assign cmp_o.eq  = flags_i.zero;
  assign cmp_o.ugt = flags_i.carry & ~flags_i.zero;
  assign cmp_o.sgt = (flags_i.neg ~^ flags_i.ovf) & ~flags_i.zero;

  always_comb begin
    if (!$isunknown({cmp_o, flags_i})) begin
      p_eq_ugt_r7: assert ($onehot0({cmp_o.eq, cmp_o.ugt}));
      p_eq_sgt_r8: assert ($onehot0({cmp_o.eq, cmp_o.sgt}));
    end
  end
endmodule

// File: rtl/addsub_cc.sv
module addsub_cc
  import addsub_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         neg_o,
  output logic         zero_o,
  output logic         carry_o,
  output logic         ovf_o,
  output logic         eq_o,
  output logic         ugt_o,
  output logic         sgt_o
);
  logic [W-1:0] b_eff;
  logic         cin;
  logic [W-1:0] sum;
  logic         cout, cmsb;
  cc_flags_t    flags;
  cmp_t         cmp;

  addsub_operand #(.W(W)) u_operand (
    .b_i(b_i), .sub_i(sub_i), .b_eff_o(b_eff), .cin_o(cin)
  );

  addsub_prefix #(.W(W)) u_prefix (
    .a_i(a_i), .b_i(b_eff), .cin_i(cin),
    .sum_o(sum), .cout_o(cout), .cmsb_o(cmsb)
  );

  addsub_flags #(.W(W)) u_flags (
    .sum_i(sum), .cout_i(cout), .cmsb_i(cmsb),
    .a_msb_i(a_i[W-1]), .b_msb_i(b_eff[W-1]), .flags_o(flags)
  );

  addsub_cmp u_cmp (.flags_i(flags), .cmp_o(cmp));

  assign res_o   = sum;
  assign neg_o   = flags.neg;
  assign zero_o  = flags.zero;
  assign carry_o = flags.carry;
  assign ovf_o   = flags.ovf;
  assign eq_o    = cmp.eq;
  assign ugt_o   = cmp.ugt;
  assign sgt_o   = cmp.sgt;

  always_comb begin
    if (!$isunknown({a_i, b_i, sub_i}) && sub_i) begin
      p_eq_r6:     assert (eq_o == (a_i == b_i));
      p_borrow_r2: assert (carry_o == (a_i >= b_i));
      p_ugt_r7:    assert (ugt_o == (a_i > b_i));
      p_sgt_r8:    assert (sgt_o == ($signed(a_i) > $signed(b_i)));
    end
  end
endmodule

// File: tb/addsub_cc_tb.sv
module addsub_cc_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    int     w;
    bit     sub;
    longint ua, ub;
    longint res;
    bit     neg, zero, carry, ovf, eq, ugt, sgt;
  } exp_t;

  exp_t q32[$];
  exp_t q4[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] a32, b32, r32;
  logic        s32, n32, z32, c32, v32, e32, u32, g32;
  logic [3:0]  a4, b4, r4;
  logic        s4, n4, z4, c4, v4, e4, u4, g4;

  addsub_cc #(.W(32)) u_dut (
    .a_i(a32), .b_i(b32), .sub_i(s32), .res_o(r32), .neg_o(n32), .zero_o(z32),
    .carry_o(c32), .ovf_o(v32), .eq_o(e32), .ugt_o(u32), .sgt_o(g32)
  );

  addsub_cc #(.W(4)) u_dut4 (
    .a_i(a4), .b_i(b4), .sub_i(s4), .res_o(r4), .neg_o(n4), .zero_o(z4),
    .carry_o(c4), .ovf_o(v4), .eq_o(e4), .ugt_o(u4), .sgt_o(g4)
  );

  function automatic exp_t model(int w, longint ua, longint ub, bit sub);
    exp_t e;
    longint m, half, sa, sb, r, sr;
    m = longint'(1) << w;
    half = m >> 1;
    sa = (ua >= half) ? ua - m : ua;
    sb = (ub >= half) ? ub - m : ub;
    r  = sub ? ua - ub : ua + ub;
    sr = sub ? sa - sb : sa + sb;
    e.w = w; e.sub = sub; e.ua = ua; e.ub = ub;
    e.res   = r & (m - 1);
    e.carry = sub ? (ua >= ub) : (r >= m);
    e.ovf   = (sr >= half) || (sr < -half);
    e.neg   = ((e.res >> (w - 1)) & 1) != 0;
    e.zero  = (e.res == 0);
    e.eq    = (ua == ub);
    e.ugt   = (ua > ub);
    e.sgt   = (sa > sb);
    return e;
  endfunction

  task automatic chk(string req, longint act, longint exp, exp_t e);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s w=%0d sub=%0d a=%0h b=%0h actual=%0h expected=%0h",
               req, e.w, e.sub, e.ua, e.ub, act, exp);
    end
  endtask

  task automatic compare(exp_t e, longint res, bit n, bit z, bit c, bit v,
                         bit eq, bit ug, bit sg);
    chk(e.sub ? "R2" : "R1", res, e.res, e);
    chk(e.sub ? "R2" : "R1", longint'(c), longint'(e.carry), e);
    chk("R3", longint'(v), longint'(e.ovf), e);
    chk("R4", longint'(n), longint'(e.neg), e);
    chk("R5", longint'(z), longint'(e.zero), e);
    if (e.sub) begin
      chk("R6", longint'(eq), longint'(e.eq), e);
      chk("R7", longint'(ug), longint'(e.ugt), e);
      chk("R8", longint'(sg), longint'(e.sgt), e);
    end
  endtask

  // driver: change inputs just after posedge, push expectation
  task automatic drive32(logic [31:0] a, logic [31:0] b, bit sub);
    @(posedge clk);
    #1;
    a32 = a; b32 = b; s32 = sub;
    q32.push_back(model(32, longint'(a), longint'(b), sub));
  endtask

  task automatic drive4(logic [3:0] a, logic [3:0] b, bit sub);
    @(posedge clk);
    #1;
    a4 = a; b4 = b; s4 = sub;
    q4.push_back(model(4, longint'(a), longint'(b), sub));
  endtask

  // monitor: sample at negedge, mid-cycle (R9: same-cycle response)
  always @(negedge clk) begin
    if (rst_ni && q32.size() > 0) begin
      exp_t e;
      e = q32.pop_front();
      compare(e, longint'(r32), n32, z32, c32, v32, e32, u32, g32);
    end
    if (rst_ni && q4.size() > 0) begin
      exp_t e;
      e = q4.pop_front();
      compare(e, longint'(r4), n4, z4, c4, v4, e4, u4, g4);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    a32 = '0; b32 = '0; s32 = 1'b0;
    a4 = '0; b4 = '0; s4 = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // idle state with zero operands: R5, R9
    checks++;
    if (r32 !== 32'h0 || z32 !== 1'b1) begin
      errors++;
      $display("FAIL R5 idle actual=%0h/%0b expected=0/1", r32, z32);
    end

    // directed corners, 32 bits
    drive32(32'h0, 32'h0, 1'b0);
    drive32(32'hFFFF_FFFF, 32'h1, 1'b0);          // R1 unsigned wrap
    drive32(32'h7FFF_FFFF, 32'h1, 1'b0);          // R3 positive overflow
    drive32(32'h8000_0000, 32'h8000_0000, 1'b0);  // R3 negative overflow
    drive32(32'h8000_0000, 32'h1, 1'b1);          // R3 sub overflow
    drive32(32'h0, 32'h1, 1'b1);                  // R2 borrow
    drive32(32'h1234_5678, 32'h1234_5678, 1'b1);  // R6 equal
    drive32(32'h8000_0000, 32'h8000_0000, 1'b1);  // R8 equal most negative
    drive32(32'h8000_0000, 32'h7FFF_FFFF, 1'b1);  // R7 R8 disagree
    drive32(32'h7FFF_FFFF, 32'h8000_0000, 1'b1);
    drive32(32'h0, 32'h8000_0000, 1'b1);
    drive32(32'hFFFF_FFFF, 32'h0, 1'b1);
    for (int i = 0; i < 3000; i++) begin
      drive32($urandom, $urandom, 1'($urandom));
    end
    // exhaustive 4-bit
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          drive4(4'(a), 4'(b), 1'(s));
        end
      end
    end
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule